// File: doc/BRIEF.md
# Packed Sub-Element Dot-Product Accumulator

This unit treats each element of two source operands as a small vector of equal, narrower sub-elements. It multiplies the sub-elements that share a lane position, adds the products together, and folds the total into an old destination value. The element width is a build-time parameter (32 by default). The number of sub-elements per element (the division factor) is picked per element by a 2-bit code. A second control bit chooses whether sub-elements are read as two's-complement or as unsigned numbers. A per-element enable bit lets a disabled element pass its old destination value through unchanged.

The number of meaningful result bits shrinks as the division factor grows. That count is the element width clamped between 8 and four times the sub-element width. The result is then widened back to the full element, with sign or zero extension.

Operands arrive on a valid/ready input stream and results leave on a valid/ready output stream. Latency is a fixed two cycles and throughput is one element per cycle. The input is ready whenever the output register is empty or is being drained in the same cycle, so a stall on the output freezes the whole pipe. A result held under back-pressure keeps its data steady until it is taken. No element is dropped, duplicated or reordered.

Top module: `subword_dot_acc`

## Requirements
- R1: Code 0, 1, 2, 3 on `in_div` selects a division factor of 1, 2, 4, 8. With SW = ELEM_W / factor, sub-element k occupies bits [k*SW +: SW] of each source, and only sub-elements with the same k are multiplied together.
- R2: For an enabled element, the low RW bits of the result equal (the low RW bits of `in_acc` plus the sum over k of the sub-element products), modulo 2^RW.
- R3: RW = max(8, min(ELEM_W, 4*ELEM_W/factor)). Result bits at and above RW repeat bit RW-1 when `in_signed` is 1 and are 0 when it is 0.
- R4: With `in_signed` = 1 each sub-element is read as a two's-complement number. With `in_signed` = 0 each is read as an unsigned number.
- R5: With code 0 the result is `in_acc + in_src_a * in_src_b` modulo 2^ELEM_W.
- R6: When `in_enable` is 0 the element still produces an output beat, and its data equals `in_acc` unchanged.
- R7: With `out_ready` held at 1, an element accepted at a clock edge appears on `out_valid`/`out_data` after the second following edge. One element can be accepted every cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays stable. `in_ready` is 1 whenever `out_valid` is 0. Outputs leave in acceptance order.
- R9: While and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat |
| in_src_a | input | ELEM_W | First source element |
| in_src_b | input | ELEM_W | Second source element |
| in_acc | input | ELEM_W | Old destination value |
| in_signed | input | 1 | 1: signed sub-elements and sign extension |
| in_div | input | 2 | Division code (0..3 gives factor 1, 2, 4, 8) |
| in_enable | input | 1 | 0: pass old destination value through |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result beat |
| out_data | output | ELEM_W | New destination value |

## Verification
The bench builds the unit with ELEM_W = 16. With that width the four codes give sub-elements of 16, 8, 4 and 2 bits and result widths of 16, 16, 16 and 8. Both the element-width clamp and the four-times-sub-element limit are therefore reached, and the 2-bit lanes hit their sign boundary on most operands. Every code and signedness pair gets streamed corner and pseudo-random operands while the output ready is toggled, so stalls, holds and back-to-back beats are all exercised against an arithmetic model.

// File: rtl/sdot_pkg.sv
package sdot_pkg;

  // Number of selectable division codes (factor = 1 << code).
  localparam int unsigned DIV_KINDS = 4;

  // Significant result bits for a given element width and division code:
  // four times the sub-element width, capped at the element, floored at 8.
  function automatic int unsigned res_width(input int unsigned elem_w, input logic [1:0] code);
    int unsigned q;
    q = (4 * elem_w) >> code;
    if (q > elem_w) q = elem_w;
    if (q < 8) q = 8;
    return q;
  endfunction

endpackage

// File: rtl/sdot_lanes.sv
module sdot_lanes
  import sdot_pkg::*;
#(
  parameter int unsigned ELEM_W = 32
) (
  input  logic [ELEM_W-1:0] src_a,
  input  logic [ELEM_W-1:0] src_b,
  input  logic              is_signed,
  input  logic [1:0]        div,
  output logic [ELEM_W-1:0] prod_sum
);

  logic [ELEM_W-1:0] div_sum [DIV_KINDS];

  // One product tree per division factor; the code picks one at the end.
  for (genvar j = 0; j < DIV_KINDS; j++) begin : g_div
    localparam int unsigned N  = 1 << j;
    localparam int unsigned SW = ELEM_W / N;
    localparam logic [ELEM_W-1:0] HI = {ELEM_W{1'b1}} << SW;

    logic [ELEM_W-1:0] prod [N];
    logic [ELEM_W-1:0] part [N+1];

    assign part[0] = '0;

    for (genvar k = 0; k < N; k++) begin : g_lane
      logic [SW-1:0]     xa, xb;
      logic [ELEM_W-1:0] ea, eb;
      assign xa = src_a[k*SW +: SW];
      assign xb = src_b[k*SW +: SW];
      assign ea = ELEM_W'(xa) | ((is_signed && xa[SW-1]) ? HI : '0);
      assign eb = ELEM_W'(xb) | ((is_signed && xb[SW-1]) ? HI : '0);
      assign prod[k] = ea * eb;
      assign part[k+1] = part[k] + prod[k];
    end

    assign div_sum[j] = part[N];
  end

  assign prod_sum = div_sum[div];

endmodule

// File: rtl/sdot_finish.sv
module sdot_finish
  import sdot_pkg::*;
#(
  parameter int unsigned ELEM_W = 32
) (
  input  logic [ELEM_W-1:0] prod_sum,
  input  logic [ELEM_W-1:0] old_acc,
  input  logic              is_signed,
  input  logic [1:0]        div,
  input  logic              enable,
  output logic [ELEM_W-1:0] result
);

  localparam int unsigned IDX_W = $clog2(ELEM_W);

  logic [ELEM_W-1:0] total;
  logic [ELEM_W-1:0] keep;
  logic [ELEM_W-1:0] ext;
  logic              top_bit;
  int unsigned       rw;

  always_comb begin
    rw      = res_width(ELEM_W, div);
    total   = old_acc + prod_sum;
    keep    = ~({ELEM_W{1'b1}} << rw);
    top_bit = total[IDX_W'(rw - 1)];
    ext     = (total & keep) | ({ELEM_W{is_signed & top_bit}} & ~keep);
    result  = enable ? ext : old_acc;
  end

endmodule

// File: rtl/subword_dot_acc.sv
module subword_dot_acc
  import sdot_pkg::*;
#(
  parameter int unsigned ELEM_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ELEM_W-1:0] in_src_a,
  input  logic [ELEM_W-1:0] in_src_b,
  input  logic [ELEM_W-1:0] in_acc,
  input  logic              in_signed,
  input  logic [1:0]        in_div,
  input  logic              in_enable,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ELEM_W-1:0] out_data
);

  logic              adv;
  logic [ELEM_W-1:0] lane_sum;
  logic [ELEM_W-1:0] fin_res;

  logic              s1_valid;
  logic [ELEM_W-1:0] s1_sum;
  logic [ELEM_W-1:0] s1_old;
  logic              s1_sgn;
  logic [1:0]        s1_div;
  logic              s1_en;

  logic              o_valid;
  logic [ELEM_W-1:0] o_data;

  // Whole pipe moves when the output slot is free or being drained.
  assign adv      = !o_valid || out_ready;
  assign in_ready = adv;

  sdot_lanes #(.ELEM_W(ELEM_W)) u_lanes (
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .is_signed(in_signed),
    .div      (in_div),
    .prod_sum (lane_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else if (adv) s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      s1_sum <= lane_sum;
      s1_old <= in_acc;
      s1_sgn <= in_signed;
      s1_div <= in_div;
      s1_en  <= in_enable;
    end
  end

  sdot_finish #(.ELEM_W(ELEM_W)) u_finish (
    .prod_sum (s1_sum),
    .old_acc  (s1_old),
    .is_signed(s1_sgn),
    .div      (s1_div),
    .enable   (s1_en),
    .result   (fin_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_valid <= 1'b0;
    else if (adv) o_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && s1_valid) o_data <= fin_res;
  end

  assign out_valid = o_valid;
  assign out_data  = o_data;

  // Unsigned results carry nothing above the significant width.
  assert_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_en && !s1_sgn) |-> ((fin_res >> res_width(ELEM_W, s1_div)) == '0));

  // A disabled element leaves with its old destination value.
  assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_en && adv) |=> (out_valid && out_data == $past(s1_old)));

  // Accepted beat reaches the output two edges later when not stalled.
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  // Held result stays put under back-pressure.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // Empty output slot never blocks the input.
  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/subword_dot_acc_bench.sv
`timescale 1ns/1ps
module subword_dot_acc_bench;

  localparam int unsigned W = 16;
  localparam int PER_CFG = 1500;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_src_a = '0, in_src_b = '0, in_acc = '0;
  logic         in_signed = 1'b0;
  logic [1:0]   in_div = 2'd0;
  logic         in_enable = 1'b1;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  bit stall_mode = 0;
  bit hold_pending = 0;
  logic [W-1:0] hold_data;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  always #2.5 clk = ~clk;

  subword_dot_acc #(.ELEM_W(W)) u_subword_dot_acc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_acc(in_acc),
    .in_signed(in_signed), .in_div(in_div), .in_enable(in_enable),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: got hang expected completion");
      report();
      $finish;
    end
  end

  // Arithmetic model of the requirements.
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [W-1:0] d, input logic [1:0] code,
                                         input logic sg, input logic en);
    int n, sw, rw;
    longint acc, x, y, msk;
    logic [W-1:0] r;
    if (!en) return d;
    n  = 1 << code;
    sw = W / n;
    rw = (4 * W) / n;
    if (rw > W) rw = W;
    if (rw < 8) rw = 8;
    msk = (longint'(1) << sw) - 1;
    acc = longint'(d);
    for (int k = 0; k < n; k++) begin
      x = longint'(a >> (k * sw)) & msk;
      y = longint'(b >> (k * sw)) & msk;
      if (sg && x[sw-1]) x = x - (longint'(1) << sw);
      if (sg && y[sw-1]) y = y - (longint'(1) << sw);
      acc = acc + x * y;
    end
    for (int i = 0; i < W; i++) r[i] = (i < rw) ? acc[i] : (sg & acc[rw-1]);
    return r;
  endfunction

  task automatic expect_eq(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle, called just after a falling edge with inputs already driven.
  task automatic step(output bit accepted);
    out_ready = stall_mode ? ($urandom_range(3) != 0) : 1'b1;
    #1;
    if (hold_pending) begin
      checks++;
      if (!out_valid || out_data !== hold_data) begin
        errors++;
        $display("FAIL R8 hold: got v=%0b %h expected v=1 %h", out_valid, out_data, hold_data);
      end
    end
    hold_pending = out_valid && !out_ready;
    hold_data = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8 order: got extra beat %h expected none", out_data);
      end else begin
        expect_eq(tag_q.pop_front(), out_data, exp_q.pop_front());
      end
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(model(in_src_a, in_src_b, in_acc, in_div, in_signed, in_enable));
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d,
                       input logic [1:0] code, input logic sg, input logic en, input string tag);
    bit acc_done;
    in_src_a = a; in_src_b = b; in_acc = d;
    in_div = code; in_signed = sg; in_enable = en;
    in_valid = 1'b1;
    tag_q.push_back(tag);
    acc_done = 0;
    while (!acc_done) step(acc_done);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    bit dummy;
    in_valid = 1'b0;
    while (exp_q.size() != 0) step(dummy);
    step(dummy);
  endtask

  function automatic string pick_tag(input logic [1:0] code, input logic sg, input logic en);
    if (!en) return "R6";
    if (code == 2'd3) return "R3";
    if (code == 2'd0) return "R5";
    if (sg) return "R4";
    return "R2";
  endfunction

  initial begin
    logic [W-1:0] corners [8];
    logic [31:0] r1, r2, r3;
    logic [W-1:0] a, b, d;
    logic en;

    corners = '{16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'h0000, 16'hAAAA, 16'h5555, 16'h8888};

    // R9: reset state.
    repeat (3) @(negedge clk);
    expect_eq("R9 out_valid in reset", W'(out_valid), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R9 out_valid after reset", W'(out_valid), W'(0));
    expect_eq("R9 in_ready after reset", W'(in_ready), W'(1));

    // R7: exact latency on an empty pipe.
    in_src_a = 16'h0003; in_src_b = 16'h0005; in_acc = 16'h0010;
    in_div = 2'd0; in_signed = 1'b0; in_enable = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    expect_eq("R7 not yet valid", W'(out_valid), W'(0));
    @(posedge clk); @(negedge clk);
    expect_eq("R7 valid after two edges", W'(out_valid), W'(1));
    expect_eq("R7 data", out_data, 16'h001F);
    @(posedge clk); @(negedge clk);

    // R1: lane pairing, crossed lanes would give different sums.
    issue(16'h0102, 16'h0300, 16'h0000, 2'd1, 1'b0, 1'b1, "R1");   // 1*3 + 2*0 = 3
    issue(16'h1234, 16'h0001, 16'h0000, 2'd2, 1'b0, 1'b1, "R1");   // only lane 0: 4*1
    issue(16'h4000, 16'h0001, 16'h0000, 2'd3, 1'b0, 1'b1, "R1");   // lane 7 and lane 0 disjoint
    issue(16'hFFFF, 16'hFFFF, 16'h0001, 2'd0, 1'b1, 1'b1, "R5");   // -1*-1 + 1 = 2
    issue(16'h00FF, 16'h00FF, 16'h0000, 2'd1, 1'b1, 1'b1, "R4");   // -1*-1 = 1
    issue(16'hBEEF, 16'h1234, 16'hCAFE, 2'd2, 1'b1, 1'b0, "R6");
    drain();

    // Streamed sweep over every code and signedness with back-pressure.
    stall_mode = 1;
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int i = 0; i < PER_CFG; i++) begin
        r1 = $urandom; r2 = $urandom; r3 = $urandom;
        a = (i < 64) ? corners[i % 8] : r1[W-1:0];
        b = (i < 64) ? corners[(i / 8) % 8] : r2[W-1:0];
        d = (i < 64) ? corners[(i + 3) % 8] : r3[W-1:0];
        en = (i % 7) != 3;
        issue(a, b, d, cfg[1:0], cfg[2], en, pick_tag(cfg[1:0], cfg[2], en));
      end
    end
    drain();
    stall_mode = 0;

    finished = 1;
    report();
    $finish;
  end

endmodule